// File: doc/BRIEF.md
# SDRAM write burst sequencer

This block sits on the controller side of a single-data-rate SDRAM and carries out one write burst into a row that is already open. A request names a bank, a starting column, a burst length code (a fixed power-of-two length or full page), a word count, a close method and an auto-precharge flag. The block issues the WRITE command with the first data word, streams the following words one per clock, and then ends the burst in one of three ways. It can let a fixed burst run out by itself, with or without auto-precharge. It can cut the burst short with BURST TERMINATE. It can close the bank with an explicit PRECHARGE, masking the data bytes and honouring the write-recovery and precharge-recovery times.

Data is pulled from the source by a per-word ready strobe. A single-cycle done pulse tells the scheduler that the bank may be used again. Write-recovery (T_DPL) and precharge-recovery (T_RP) are module parameters counted in clocks, each at least 1. A fixed burst that ends by itself without auto-precharge can be followed by a new WRITE on the very next clock.

Top module: `sdr_wr_burst_seq`

## Requirements
- R1: With the block idle, req_ready_o is high. A request accepted at a clock edge (valid and ready both high) puts WRITE (cs_n/ras_n/cas_n/we_n = 0/1/0/0) on the pins in the following cycle. The column is on addr_o[8:0], the bank is on ba_o, and addr_o bits 9, 11 and 12 are 0.
- R2: The first data word is driven in the WRITE cycle and each later word in each following cycle. dq_oe_o and wd_ready_o are high exactly in those cycles. In those cycles dq_o equals wd_data_i and dqm_o equals wd_mask_i.
- R3: Burst length code req_bl_i values 0..3 mean fixed bursts of 1, 2, 4 and 8 words. Values 4..7 mean full page. A fixed burst that ends by itself writes its full length. For any early close, the word count is req_len_i, with 0 taken as 1; on a fixed burst it is limited to the burst length.
- R4: addr_o[10] in the WRITE cycle equals req_ap_i only for a fixed burst with close code 0 (natural end). In every other case it is 0.
- R5: A fixed natural burst without auto-precharge raises done_o in the cycle after its last word. req_ready_o is high in the last-word cycle, so a request accepted then puts the next WRITE in the cycle right after the last word.
- R6: Close code 1 (terminate) puts BURST TERMINATE (0/1/1/0) on the pins in the cycle after the last wanted word, with dq_oe_o low. done_o is raised in the following cycle.
- R7: Close codes 2 and 3 (precharge) put PRECHARGE (0/0/1/0) on the pins T_DPL cycles after the last wanted word, with the bank on ba_o and addr_o[10] low. dqm_o is all ones and dq_oe_o is low in every cycle from the one after the last word up to and including the PRECHARGE cycle.
- R8: After a PRECHARGE only NOP is driven, and done_o rises exactly T_RP cycles after the PRECHARGE cycle.
- R9: A natural burst with auto-precharge drives only NOP after its last word and raises done_o T_DPL+T_RP cycles after the last word.
- R10: A full-page burst with close code 0 is closed as if terminate had been requested.
- R11: req_valid_i has no effect while req_ready_o is low: no WRITE appears in the cycle after any cycle with req_ready_o low.
- R12: During and after reset the block is idle: NOP on the pins, dq_oe_o, wd_ready_o, done_o and dqm_o low, and req_ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_bank_i | input | BA_W | Bank |
| req_col_i | input | COL_W | Starting column |
| req_bl_i | input | 3 | Burst length code |
| req_close_i | input | 2 | Close method: 0 natural, 1 terminate, 2/3 precharge |
| req_ap_i | input | 1 | Auto-precharge request |
| req_len_i | input | LEN_W | Wanted word count for an early close |
| wd_data_i | input | DQ_W | Write data word |
| wd_mask_i | input | DM_W | Byte mask for the word |
| wd_ready_o | output | 1 | Word consumed this cycle |
| cs_n_o | output | 1 | Chip select |
| ras_n_o | output | 1 | Row strobe |
| cas_n_o | output | 1 | Column strobe |
| we_n_o | output | 1 | Write enable |
| addr_o | output | ADDR_W | Address pins |
| ba_o | output | BA_W | Bank pins |
| dq_o | output | DQ_W | Data out |
| dq_oe_o | output | 1 | Data output enable |
| dqm_o | output | DM_W | Byte masks |
| done_o | output | 1 | Burst closed and bank recovered |

## Verification
The assertions assume the request fields are meaningful only in the cycle of acceptance. They also assume the word source presents the next word whenever wd_ready_o is high, and that T_DPL and T_RP are at least 1. The bench holds every request field steady through the accepting edge and changes them only at falling edges. It keeps a word ready at all times, indexed by the count of words already consumed. It never lowers reset at a rising edge.

// File: rtl/sdr_wr_pkg.sv
package sdr_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_GAP, ST_PRE, ST_WAIT, ST_BST
  } state_e;

  typedef enum logic [1:0] {CL_NAT, CL_TERM, CL_PRE} close_e;

  typedef enum logic [1:0] {CMD_NOP, CMD_WRITE, CMD_BST, CMD_PRE} cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t cmd_pins(cmd_e c);
    unique case (c)
      CMD_WRITE: return 4'b0100;
      CMD_BST:   return 4'b0110;
      CMD_PRE:   return 4'b0010;
      default:   return 4'b0111;
    endcase
  endfunction
endpackage

// File: rtl/sdr_wr_req_decode.sv
module sdr_wr_req_decode
  import sdr_wr_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic [2:0]       bl_i,
  input  logic [1:0]       close_i,
  input  logic             ap_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] words_m1_o,
  output close_e           close_o,
  output logic             ap_o
);
  logic             full;
  logic [LEN_W-1:0] bl_words, len_nz, len_fix, words;

  assign full     = bl_i[2];
  assign bl_words = LEN_W'(1) << bl_i[1:0];
  assign len_nz   = (len_i == '0) ? LEN_W'(1) : len_i;
  assign len_fix  = (len_nz > bl_words) ? bl_words : len_nz;

  always_comb begin
    if (close_i[1])      close_o = CL_PRE;
    else if (close_i[0]) close_o = CL_TERM;
    else if (full)       close_o = CL_TERM;  // full page never ends by itself
    else                 close_o = CL_NAT;
  end

  assign ap_o = ap_i & (close_i == 2'b00) & ~full;

  always_comb begin
    if (full)                 words = len_nz;
    else if (close_o == CL_NAT) words = bl_words;
    else                      words = len_fix;
  end

  assign words_m1_o = words - LEN_W'(1);
endmodule

// File: rtl/sdr_wr_fsm.sv
module sdr_wr_fsm
  import sdr_wr_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int BA_W  = 2,
  parameter int COL_W = 9,
  parameter int T_DPL = 2,
  parameter int T_RP  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [LEN_W-1:0] words_m1_i,
  input  close_e           close_i,
  input  logic             ap_i,
  output state_e           state_o,
  output logic             first_o,
  output logic             ready_o,
  output logic             done_o,
  output logic [BA_W-1:0]  bank_o,
  output logic [COL_W-1:0] col_o,
  output logic             ap_o
);
  localparam int TMR_W = $clog2(T_DPL + T_RP + 1);

  state_e           st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, last_q;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  close_e           close_q;
  logic             done_q, done_d;
  logic             last, accept, load;

  assign last    = (cnt_q == last_q);
  assign ready_o = (st_q == ST_IDLE) |
                   ((st_q == ST_DATA) & last & (close_q == CL_NAT) & ~ap_o);
  assign accept  = req_valid_i & ready_o;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tmr_d  = tmr_q;
    done_d = 1'b0;
    load   = 1'b0;
    unique case (st_q)
      ST_IDLE: load = accept;
      ST_DATA: begin
        if (!last) begin
          cnt_d = cnt_q + LEN_W'(1);
        end else begin
          unique case (close_q)
            CL_NAT: begin
              if (ap_o) begin
                st_d  = ST_WAIT;
                tmr_d = TMR_W'(T_DPL + T_RP - 1);
              end else begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
                load   = accept;
              end
            end
            CL_TERM: st_d = ST_BST;
            default: begin
              if (T_DPL > 1) begin
                st_d  = ST_GAP;
                tmr_d = TMR_W'(T_DPL - 1);
              end else begin
                st_d = ST_PRE;
              end
            end
          endcase
        end
      end
      ST_GAP: begin
        if (tmr_q == TMR_W'(1)) st_d = ST_PRE;
        else                    tmr_d = tmr_q - TMR_W'(1);
      end
      ST_PRE: begin
        if (T_RP > 1) begin
          st_d  = ST_WAIT;
          tmr_d = TMR_W'(T_RP - 1);
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_WAIT: begin
        if (tmr_q == TMR_W'(1)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          tmr_d = tmr_q - TMR_W'(1);
        end
      end
      ST_BST: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (load) begin
      st_d  = ST_DATA;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      tmr_q   <= '0;
      done_q  <= 1'b0;
      last_q  <= '0;
      close_q <= CL_NAT;
      ap_o    <= 1'b0;
      bank_o  <= '0;
      col_o   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tmr_q  <= tmr_d;
      done_q <= done_d;
      if (load) begin
        last_q  <= words_m1_i;
        close_q <= close_i;
        ap_o    <= ap_i;
        bank_o  <= bank_i;
        col_o   <= col_i;
      end
    end
  end

  assign state_o = st_q;
  assign first_o = (cnt_q == '0);
  assign done_o  = done_q;
endmodule

// File: rtl/sdr_wr_pin_drive.sv
module sdr_wr_pin_drive
  import sdr_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int BA_W   = 2,
  parameter int DQ_W   = 32,
  parameter int DM_W   = 4
) (
  input  state_e            state_i,
  input  logic              first_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic [DQ_W-1:0]   wd_data_i,
  input  logic [DM_W-1:0]   wd_mask_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic [DM_W-1:0]   dqm_o,
  output logic              wd_ready_o
);
  cmd_e  cmd;
  pins_t pins;
  logic  is_wr, data_ph, masked;

  always_comb begin
    unique case (state_i)
      ST_DATA: cmd = first_i ? CMD_WRITE : CMD_NOP;
      ST_BST:  cmd = CMD_BST;
      ST_PRE:  cmd = CMD_PRE;
      default: cmd = CMD_NOP;
    endcase
  end

  assign pins    = cmd_pins(cmd);
  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;

  assign is_wr = (cmd == CMD_WRITE);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
    if (i < COL_W) begin : g_col
      assign addr_o[i] = is_wr & col_i[i];
    end else if (i == AP_BIT) begin : g_ap
      assign addr_o[i] = is_wr & ap_i;   // stays low on PRECHARGE: single bank
    end else begin : g_zero
      assign addr_o[i] = 1'b0;
    end
  end

  assign ba_o = (is_wr || cmd == CMD_PRE) ? bank_i : '0;

  assign data_ph    = (state_i == ST_DATA);
  assign masked     = (state_i == ST_GAP) | (state_i == ST_PRE);
  assign dq_oe_o    = data_ph;
  assign wd_ready_o = data_ph;
  assign dq_o       = data_ph ? wd_data_i : '0;
  assign dqm_o      = data_ph ? wd_mask_i : (masked ? '1 : '0);
endmodule

// File: rtl/sdr_wr_burst_seq.sv
module sdr_wr_burst_seq
  import sdr_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int BA_W   = 2,
  parameter int DQ_W   = 32,
  parameter int LEN_W  = 10,
  parameter int T_DPL  = 2,
  parameter int T_RP   = 3,
  localparam int DM_W  = DQ_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [2:0]        req_bl_i,
  input  logic [1:0]        req_close_i,
  input  logic              req_ap_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [DQ_W-1:0]   wd_data_i,
  input  logic [DM_W-1:0]   wd_mask_i,
  output logic              wd_ready_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic [DM_W-1:0]   dqm_o,
  output logic              done_o
);
  logic [LEN_W-1:0] words_m1;
  close_e           close_eff;
  logic             ap_eff, first, ap_q;
  state_e           state;
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] col_q;

  sdr_wr_req_decode #(.LEN_W(LEN_W)) u_dec (
    .bl_i      (req_bl_i),
    .close_i   (req_close_i),
    .ap_i      (req_ap_i),
    .len_i     (req_len_i),
    .words_m1_o(words_m1),
    .close_o   (close_eff),
    .ap_o      (ap_eff)
  );

  sdr_wr_fsm #(
    .LEN_W(LEN_W), .BA_W(BA_W), .COL_W(COL_W), .T_DPL(T_DPL), .T_RP(T_RP)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .bank_i     (req_bank_i),
    .col_i      (req_col_i),
    .words_m1_i (words_m1),
    .close_i    (close_eff),
    .ap_i       (ap_eff),
    .state_o    (state),
    .first_o    (first),
    .ready_o    (req_ready_o),
    .done_o     (done_o),
    .bank_o     (bank_q),
    .col_o      (col_q),
    .ap_o       (ap_q)
  );

  sdr_wr_pin_drive #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .BA_W(BA_W),
    .DQ_W(DQ_W), .DM_W(DM_W)
  ) u_pins (
    .state_i   (state),
    .first_i   (first),
    .bank_i    (bank_q),
    .col_i     (col_q),
    .ap_i      (ap_q),
    .wd_data_i (wd_data_i),
    .wd_mask_i (wd_mask_i),
    .cs_n_o    (cs_n_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .we_n_o    (we_n_o),
    .addr_o    (addr_o),
    .ba_o      (ba_o),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o),
    .dqm_o     (dqm_o),
    .wd_ready_o(wd_ready_o)
  );
endmodule

// File: rtl/sdr_wr_burst_seq_chk.sv
module sdr_wr_burst_seq_chk #(
  parameter int DM_W  = 4,
  parameter int T_DPL = 2,
  parameter int T_RP  = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            bl_full_i,
  input logic [1:0]      req_close_i,
  input logic            req_ap_i,
  input logic            cs_n_o,
  input logic            ras_n_o,
  input logic            cas_n_o,
  input logic            we_n_o,
  input logic            ap_pin_i,
  input logic            dq_oe_o,
  input logic [DM_W-1:0] dqm_o,
  input logic            wd_ready_o,
  input logic            done_o
);
  localparam int RP_W = $clog2(T_RP + 1);

  logic [3:0]      pins;
  logic            wr_c, bst_c, pre_c, nop_c;
  logic [7:0]      since_q;
  logic [RP_W-1:0] rp_q;

  assign pins  = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign wr_c  = (pins == 4'b0100);
  assign bst_c = (pins == 4'b0110);
  assign pre_c = (pins == 4'b0010);
  assign nop_c = (pins == 4'b0111);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      rp_q    <= '0;
    end else begin
      if (dq_oe_o)              since_q <= 8'd1;
      else if (since_q != 8'hff) since_q <= since_q + 8'd1;
      if (pre_c)                rp_q <= RP_W'(T_RP - 1);
      else if (rp_q != '0)      rp_q <= rp_q - RP_W'(1);
    end
  end

  a_r1_accept_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> wr_c);

  a_r2_write_with_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_c |-> dq_oe_o && wd_ready_o);

  a_r4_ap_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_c |-> ap_pin_i == $past(req_ap_i && req_close_i == 2'b00 && !bl_full_i));

  a_r6_bst_after_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bst_c |-> !dq_oe_o && $past(dq_oe_o));

  a_r7_pre_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_c |-> dqm_o == '1 && !dq_oe_o && since_q == 8'(T_DPL));

  a_r8_trp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rp_q != '0 |-> nop_c && !dq_oe_o);

  a_r8_done_after_trp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rp_q == RP_W'(1) |=> done_o);

  a_r11_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> !wr_c);
endmodule

bind sdr_wr_burst_seq sdr_wr_burst_seq_chk #(
  .DM_W(DM_W), .T_DPL(T_DPL), .T_RP(T_RP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .bl_full_i  (req_bl_i[2]),
  .req_close_i(req_close_i),
  .req_ap_i   (req_ap_i),
  .cs_n_o     (cs_n_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .ap_pin_i   (addr_o[AP_BIT]),
  .dq_oe_o    (dq_oe_o),
  .dqm_o      (dqm_o),
  .wd_ready_o (wd_ready_o),
  .done_o     (done_o)
);

// File: tb/tb_sdr_wr_burst_seq.sv
module tb_sdr_wr_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TDPL = 2;
  localparam int TRP  = 3;

  typedef struct packed {
    logic [2:0] bl;
    logic [1:0] cl;
    logic       ap;
    logic [9:0] len;
    logic [1:0] bank;
    logic [8:0] col;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 2'd0, 1'b0, 10'd0,  2'd1, 9'h010},  // fixed 4, natural
    '{3'd3, 2'd0, 1'b1, 10'd0,  2'd2, 9'h0a8},  // fixed 8, auto-precharge
    '{3'd0, 2'd0, 1'b0, 10'd7,  2'd0, 9'h1ff},  // fixed 1, natural
    '{3'd3, 2'd1, 1'b1, 10'd3,  2'd3, 9'h033},  // terminate, ap ignored
    '{3'd7, 2'd1, 1'b0, 10'd20, 2'd1, 9'h100},  // full page terminate
    '{3'd2, 2'd2, 1'b0, 10'd2,  2'd2, 9'h004},  // precharge close
    '{3'd1, 2'd3, 1'b0, 10'd9,  2'd3, 9'h155},  // precharge, len clamped
    '{3'd7, 2'd0, 1'b1, 10'd5,  2'd0, 9'h0f0},  // full page natural -> terminate
    '{3'd4, 2'd2, 1'b0, 10'd0,  2'd1, 9'h001},  // full page, len 0 -> 1
    '{3'd1, 2'd0, 1'b1, 10'd0,  2'd2, 9'h0c3}   // fixed 2, auto-precharge
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_ap = 1'b0;
  logic [1:0]  req_bank = '0, req_close = '0, ba;
  logic [8:0]  req_col = '0;
  logic [2:0]  req_bl = '0;
  logic [9:0]  req_len = '0;
  logic [31:0] wd_data = '0, dq;
  logic [3:0]  wd_mask = '0, dqm;
  logic        wd_ready, cs_n, ras_n, cas_n, we_n, dq_oe, done;
  logic [12:0] addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_wr_burst_seq #(.T_DPL(TDPL), .T_RP(TRP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_col_i(req_col), .req_bl_i(req_bl),
    .req_close_i(req_close), .req_ap_i(req_ap), .req_len_i(req_len),
    .wd_data_i(wd_data), .wd_mask_i(wd_mask), .wd_ready_o(wd_ready),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .addr_o(addr), .ba_o(ba), .dq_o(dq), .dq_oe_o(dq_oe), .dqm_o(dqm),
    .done_o(done)
  );

  // 0 NOP, 1 WRITE, 2 BURST TERMINATE, 3 PRECHARGE, 4 other
  function automatic int cmd_of();
    case ({cs_n, ras_n, cas_n, we_n})
      4'b0111: return 0;
      4'b0100: return 1;
      4'b0110: return 2;
      4'b0010: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] data_of(int v, int idx);
    return {8'(v), 8'h5a, 16'(idx)};
  endfunction

  function automatic logic [3:0] mask_of(int idx);
    return (idx % 3 == 2) ? 4'b0101 : 4'b0000;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(int vi);
    vec_t v = VECS[vi];
    bit full = v.bl[2];
    int blw = 1 << v.bl[1:0];
    bit nat = (v.cl == 2'd0), pre = v.cl[1];
    bit term = (v.cl == 2'd1) || (nat && full);
    int lenv = (v.len == 0) ? 1 : int'(v.len);
    int ew, ed, ecl, ecc, em;
    bit eap = v.ap && nat && !full;
    int words = 0, wr_k = -1, cl_k = -1, cl_c = -1, masks = 0, bad = 0, done_k = -1;
    int a10 = -1, colv = -1, bav = -1, hi = -1, pre_ba = -1, pre_a10 = -1, rdy_k = 0;

    if (nat && !full) ew = blw;
    else if (!full && lenv > blw) ew = blw;
    else ew = lenv;
    if (term) begin ed = ew + 2; ecl = ew + 1; ecc = 2; em = 0; end
    else if (pre) begin ed = ew + TDPL + TRP; ecl = ew + TDPL; ecc = 3; em = TDPL; end
    else if (eap) begin ed = ew + TDPL + TRP; ecl = -1; ecc = -1; em = 0; end
    else begin ed = ew + 1; ecl = -1; ecc = -1; em = 0; end

    @(negedge clk);
    chk("R1", $sformatf("v%0d ready before request", vi), int'(req_ready), 1);
    req_bl = v.bl; req_close = v.cl; req_ap = v.ap; req_len = v.len;
    req_bank = v.bank; req_col = v.col; req_valid = 1'b1;
    wd_data = data_of(vi, 0); wd_mask = mask_of(0);
    @(posedge clk);
    for (int k = 1; k < 1200; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (req_ready && k < ew) rdy_k++;
      if (cmd_of() == 1) begin
        wr_k = k; a10 = int'(addr[10]); colv = int'(addr[8:0]); bav = int'(ba);
        hi = int'({addr[12:11], addr[9]});
      end
      if (dq_oe) begin
        if (dq != data_of(vi, words) || dqm != mask_of(words) || !wd_ready) bad++;
        words++;
      end else if (dqm == 4'hf) masks++;
      if (cmd_of() == 2 || cmd_of() == 3) begin
        cl_k = k; cl_c = cmd_of();
        pre_ba = int'(ba); pre_a10 = int'(addr[10]);
      end
      if (done) begin done_k = k; break; end
      wd_data = data_of(vi, words); wd_mask = mask_of(words);
    end
    chk("R1", $sformatf("v%0d WRITE cycle", vi), wr_k, 1);
    chk("R1", $sformatf("v%0d column", vi), colv, int'(v.col));
    chk("R1", $sformatf("v%0d bank", vi), bav, int'(v.bank));
    chk("R1", $sformatf("v%0d unused address bits", vi), hi, 0);
    chk("R4", $sformatf("v%0d auto-precharge pin", vi), a10, int'(eap));
    chk("R2", $sformatf("v%0d data/mask mismatches", vi), bad, 0);
    chk("R3", $sformatf("v%0d words written", vi), words, ew);
    chk("R11", $sformatf("v%0d ready mid-burst", vi), rdy_k, 0);
    chk(term ? (full && nat ? "R10" : "R6") : (pre ? "R7" : "R9"),
        $sformatf("v%0d close command cycle", vi), cl_k, ecl);
    chk("R6", $sformatf("v%0d close command kind", vi), cl_c, ecc);
    chk("R7", $sformatf("v%0d masked idle cycles", vi), masks, em);
    if (pre) begin
      chk("R7", $sformatf("v%0d PRECHARGE bank", vi), pre_ba, int'(v.bank));
      chk("R7", $sformatf("v%0d PRECHARGE A10", vi), pre_a10, 0);
    end
    chk(pre ? "R8" : (eap ? "R9" : (term ? "R6" : "R5")),
        $sformatf("v%0d done cycle", vi), done_k, ed);
  endtask

  task automatic idle_checks(string tag);
    chk("R12", {tag, " command NOP"}, cmd_of(), 0);
    chk("R12", {tag, " dq_oe"}, int'(dq_oe), 0);
    chk("R12", {tag, " wd_ready"}, int'(wd_ready), 0);
    chk("R12", {tag, " done"}, int'(done), 0);
    chk("R12", {tag, " dqm"}, int'(dqm), 0);
    chk("R12", {tag, " ready"}, int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_checks("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_checks("after reset");

    for (int i = 0; i < NV; i++) run_vec(i);

    // R5: back-to-back natural bursts
    @(negedge clk);
    req_bl = 3'd1; req_close = 2'd0; req_ap = 1'b0; req_len = '0;
    req_bank = 2'd2; req_col = 9'h020; req_valid = 1'b1;
    @(negedge clk);
    chk("R5", "chain first WRITE", cmd_of(), 1);
    @(negedge clk);
    chk("R5", "chain ready on last word", int'(req_ready), 1);
    chk("R5", "chain last word driven", int'(dq_oe), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5", "chain second WRITE without gap", cmd_of(), 1);
    chk("R5", "chain done on first burst", int'(done), 1);
    @(negedge clk);
    chk("R5", "chain second burst word", int'(dq_oe), 1);
    @(negedge clk);
    chk("R5", "chain done on second burst", int'(done), 1);

    // R11: valid held high while busy
    @(negedge clk);
    req_bl = 3'd7; req_close = 2'd1; req_len = 10'd2; req_valid = 1'b1;
    begin
      int early = 0, late = 0;
      @(posedge clk);
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        if (k >= 2 && k <= 4 && cmd_of() == 1) early++;
        if (k == 5) begin late = cmd_of(); req_valid = 1'b0; end
      end
      chk("R11", "no WRITE while busy", early, 0);
      chk("R11", "WRITE after release", late, 1);
      for (int k = 0; k < 20 && !done; k++) @(negedge clk);
      chk("R6", "second terminated burst done", int'(done), 1);
    end

    // R12: reset in the middle of a burst
    @(negedge clk);
    req_bl = 3'd7; req_close = 2'd2; req_len = 10'd30; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_checks("mid-burst reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_checks("after mid-burst reset");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule